// File: doc/BRIEF.md
# Time-Shared Four-Angle CORDIC Engine

The engine produces cosine and sine for a batch of four angles. It does not unroll sixteen rotation stages. Instead it chains four rotation stages into a closed ring whose last register feeds the first stage again. Each of the four angles therefore makes four trips around the ring, and in total every angle receives sixteen micro-rotations. One batch counter controls the sequence. From the counter each stage works out which pass the angle in front of it is on. Combined with its own position, the pass gives the global iteration index, and that index selects both the shift amount and the arctangent constant.

A batch starts with a `start_i` pulse. The engine then opens a load window of four transfers on a valid/ready input. Each transfer carries a target angle (signed, 3 integer bits and 13 fraction bits, within ±π/2) and a starting vector x0, y0 (signed, 2 integer bits and 14 fraction bits). Setting x0 = 9949 (≈ 1/K) and y0 = 0 gives cos and sin directly, with no gain correction. Any other vector is rotated by the angle and scaled by the CORDIC gain K ≈ 1.64676.

Back-pressure on the input works by stalling. While `in_ready_o` is high and `in_valid_i` is low, the entire ring and the counter hold their state. A transfer happens on a rising edge where both signals are high. The result side has no back-pressure. The four results appear on four consecutive cycles, flagged by `out_valid_o`, and must be captured on the cycle they are shown.

Top module: `cordic4_ring`

## Requirements
- R1: After reset, `in_ready_o` and `out_valid_o` are both low, and they stay low until a start pulse arrives.
- R2: The cycle after a `start_i` pulse, `in_ready_o` goes high. It stays high until four transfers have been accepted and then goes low. It is never high at any other time.
- R3: During the load window, a cycle with `in_valid_i` low accepts nothing. `in_ready_o` stays high through such a cycle, and the result timing moves later by one cycle for each such cycle.
- R4: The first result is visible 12 rising edges after the edge that accepts the fourth transfer. `out_valid_o` is then high for exactly four consecutive cycles.
- R5: With x0 = 9949 and y0 = 0, the results come out in the order the angles were accepted. For each angle θ, `cos_o` lies within 16 LSB of 16384·cos θ and `sin_o` lies within 16 LSB of 16384·sin θ.
- R6: For a general starting vector, `cos_o` ≈ K·(x0·cos θ − y0·sin θ) and `sin_o` ≈ K·(x0·sin θ + y0·cos θ), with K = 1.6467603 and a tolerance of 16 LSB.
- R7: A `start_i` pulse during a batch abandons that batch. None of its results appear, and the new batch runs with normal timing.
- R8: The end points ±12868 (±π/2) and angles of ±1 LSB meet the accuracy of R5.
- R9: `in_ready_o` and `out_valid_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a new batch; also abandons a batch in progress |
| in_valid_i | input | 1 | Input transfer offered |
| in_ready_o | output | 1 | Load window open, transfer accepted when both high |
| angle_i | input | 16 | Target angle, signed, 13 fraction bits |
| x0_i | input | 16 | Starting x, signed, 14 fraction bits |
| y0_i | input | 16 | Starting y, signed, 14 fraction bits |
| out_valid_o | output | 1 | A result is present this cycle |
| cos_o | output | 16 | Rotated x, signed, 14 fraction bits |
| sin_o | output | 16 | Rotated y, signed, 14 fraction bits |

## Verification
The bench inserts stall cycles into the load window. A design that lets the ring move without input would deliver results too early or with mixed-up angles, and the bench catches both the late-first-result timing and the per-angle values. The angle batches include both signs, ±π/2 and ±1 LSB. A wrong pass or stage index, a wrong shift, a wrong arctangent constant or a flipped direction sign moves those results by far more than the tolerance. Starting vectors other than (1/K, 0) expose a swapped or mis-signed cross term. A restart in the middle of a batch must produce no result, and a design that still flushed the abandoned lanes would put unexpected items in front of the scoreboard.

// File: rtl/cordic4_pkg.sv
package cordic4_pkg;

  localparam int DW = 16;  // x and y: signed, 14 fraction bits
  localparam int ZW = 16;  // angle: signed, 13 fraction bits

  typedef struct packed {
    logic signed [DW-1:0] x;
    logic signed [DW-1:0] y;
    logic signed [ZW-1:0] z;
  } cordic_vec_t;

  // arctan(2^-i) scaled by 2^13, rounded
  function automatic logic signed [ZW-1:0] atan_const(input int i);
    case (i)
      0:  return ZW'(6434);
      1:  return ZW'(3798);
      2:  return ZW'(2007);
      3:  return ZW'(1019);
      4:  return ZW'(511);
      5:  return ZW'(256);
      6:  return ZW'(128);
      7:  return ZW'(64);
      8:  return ZW'(32);
      9:  return ZW'(16);
      10: return ZW'(8);
      11: return ZW'(4);
      12: return ZW'(2);
      13: return ZW'(1);
      14: return ZW'(1);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/cordic_ce.sv
module cordic_ce
  import cordic4_pkg::*;
#(
  parameter int IW = 4
) (
  input  cordic_vec_t   v_i,
  input  logic [IW-1:0] iter_i,
  output cordic_vec_t   v_o
);

  logic signed [DW-1:0] xs, ys;
  logic signed [ZW-1:0] at;

  always_comb begin
    xs = $signed(v_i.x) >>> iter_i;
    ys = $signed(v_i.y) >>> iter_i;
    at = atan_const(int'(iter_i));
    if (!v_i.z[ZW-1]) begin
      v_o.x = v_i.x - ys;
      v_o.y = v_i.y + xs;
      v_o.z = v_i.z - at;
    end else begin
      v_o.x = v_i.x + ys;
      v_o.y = v_i.y - xs;
      v_o.z = v_i.z + at;
    end
  end

endmodule

// File: rtl/cordic_ctrl.sv
module cordic_ctrl #(
  parameter int STAGES = 4,
  parameter int PASSES = 4,
  parameter int CW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  output logic          adv_o,
  output logic          load_o,
  output logic          out_valid_o,
  output logic [CW-1:0] cnt_o
);

  localparam int ITERS = STAGES * PASSES;
  localparam int LAST  = ITERS + STAGES - 1;

  logic          run_q;
  logic [CW-1:0] cnt_q;

  assign load_o      = cnt_q < CW'(STAGES);
  assign in_ready_o  = run_q && load_o;
  assign adv_o       = run_q && (!load_o || in_valid_i);
  assign out_valid_o = run_q && (cnt_q >= CW'(ITERS));
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (adv_o) begin
      if (cnt_q == CW'(LAST)) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2
  ready_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready_o) |-> $past(start_i));

  // R3
  stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o && !in_valid_i && !start_i |=> in_ready_o && $stable(cnt_o));

  // R7
  restart_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> in_ready_o && !out_valid_o);

endmodule

// File: rtl/cordic_ring.sv
module cordic_ring
  import cordic4_pkg::*;
#(
  parameter int STAGES = 4,
  parameter int PASSES = 4,
  parameter int CW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          load_i,
  input  logic [CW-1:0] cnt_i,
  input  cordic_vec_t   seed_i,
  output cordic_vec_t   tail_o
);

  localparam int IW = $clog2(STAGES * PASSES);

  cordic_vec_t tap [STAGES];

  for (genvar j = 0; j < STAGES; j++) begin : g_stage
    cordic_vec_t   d_in, d_out, q;
    logic [IW-1:0] it;

    if (j == 0) begin : g_head
      assign d_in = load_i ? seed_i : tap[STAGES-1];
    end else begin : g_body
      assign d_in = tap[j-1];
    end

    // pass of the lane now in front of this stage, times STAGES, plus position
    assign it = IW'((int'(cnt_i) - j) / STAGES * STAGES + j);

    cordic_ce #(.IW(IW)) u_ce (
      .v_i   (d_in),
      .iter_i(it),
      .v_o   (d_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (adv_i) q <= d_out;
    end

    assign tap[j] = q;
  end

  assign tail_o = tap[STAGES-1];

endmodule

// File: rtl/cordic4_ring.sv
module cordic4_ring
  import cordic4_pkg::*;
#(
  parameter int STAGES = 4,
  parameter int PASSES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [ZW-1:0] angle_i,
  input  logic [DW-1:0] x0_i,
  input  logic [DW-1:0] y0_i,
  output logic          out_valid_o,
  output logic [DW-1:0] cos_o,
  output logic [DW-1:0] sin_o
);

  localparam int LANES = STAGES;
  localparam int CW    = $clog2(STAGES * PASSES + LANES);

  logic          adv, load;
  logic [CW-1:0] cnt;
  cordic_vec_t   seed, tail;

  cordic_ctrl #(.STAGES(STAGES), .PASSES(PASSES), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .adv_o      (adv),
    .load_o     (load),
    .out_valid_o(out_valid_o),
    .cnt_o      (cnt)
  );

  assign seed = '{x: x0_i, y: y0_i, z: angle_i};

  cordic_ring #(.STAGES(STAGES), .PASSES(PASSES), .CW(CW)) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (adv),
    .load_i(load),
    .cnt_i (cnt),
    .seed_i(seed),
    .tail_o(tail)
  );

  assign cos_o = tail.x;
  assign sin_o = tail.y;

  // run length of the current result burst
  logic [CW-1:0] burst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           burst_q <= '0;
    else if (out_valid_o) burst_q <= burst_q + 1'b1;
    else                  burst_q <= '0;
  end

  // R4
  burst_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> burst_q < CW'(LANES));

  // R4
  burst_len_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid_o) && !$past(start_i) |-> $past(burst_q) == CW'(LANES - 1));

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready_o && out_valid_o));

endmodule

// File: tb/cordic4_ring_tb.sv
module cordic4_ring_tb;

  localparam int  CLK_PERIOD = 10;
  localparam real GAIN       = 1.6467602581;
  localparam real TOL        = 16.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [15:0] angle_i = '0;
  logic [15:0] x0_i = '0;
  logic [15:0] y0_i = '0;
  logic        out_valid_o;
  logic [15:0] cos_o, sin_o;

  cordic4_ring u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .angle_i(angle_i), .x0_i(x0_i), .y0_i(y0_i),
    .out_valid_o(out_valid_o), .cos_o(cos_o), .sin_o(sin_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  real   q_c[$];
  real   q_s[$];
  string q_tag[$];
  bit    overlap_seen = 1'b0;
  int    burst = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (in_ready_o && out_valid_o) overlap_seen = 1'b1;
      if (out_valid_o) begin
        burst++;
        if (q_c.size() == 0) begin
          chk(1'b0, "R7", "unexpected result", 1.0, 0.0);
        end else begin
          real   ec, es, ac, as;
          string tg;
          ec = q_c.pop_front(); es = q_s.pop_front(); tg = q_tag.pop_front();
          ac = $itor($signed(cos_o)); as = $itor($signed(sin_o));
          chk((ac - ec <= TOL) && (ec - ac <= TOL), tg, "cos", ac, ec);
          chk((as - es <= TOL) && (es - as <= TOL), tg, "sin", as, es);
        end
      end else if (burst != 0) begin
        chk(burst == 4, "R4", "burst length", $itor(burst), 4.0);
        burst = 0;
      end
    end
  end

  task automatic run_batch(input int ang[4], input int xs[4], input int ys[4],
                           input int stall[4], input bit push, input bit wait_out,
                           input string tag);
    int n;
    @(negedge clk); start_i = 1'b1;
    @(posedge clk);
    @(negedge clk); start_i = 1'b0;
    chk(in_ready_o == 1'b1, "R2", "ready after start", $itor(in_ready_o), 1.0);
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < stall[k]; s++) begin
        in_valid_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(in_ready_o == 1'b1, "R3", "ready held in stall", $itor(in_ready_o), 1.0);
      end
      in_valid_i = 1'b1;
      angle_i = 16'(ang[k]); x0_i = 16'(xs[k]); y0_i = 16'(ys[k]);
      if (push) begin
        real th;
        th = $itor(ang[k]) / 8192.0;
        q_c.push_back(GAIN * ($itor(xs[k]) * $cos(th) - $itor(ys[k]) * $sin(th)));
        q_s.push_back(GAIN * ($itor(xs[k]) * $sin(th) + $itor(ys[k]) * $cos(th)));
        q_tag.push_back(tag);
      end
      @(posedge clk);
      @(negedge clk);
      in_valid_i = 1'b0;
    end
    chk(in_ready_o == 1'b0, "R2", "ready after four", $itor(in_ready_o), 0.0);
    if (wait_out) begin
      n = 0;
      while (!out_valid_o && n < 40) begin
        @(posedge clk);
        @(negedge clk);
        n++;
      end
      chk(n == 12, "R4", "edges to first result", $itor(n), 12.0);
      repeat (6) @(posedge clk);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready_o == 1'b0, "R1", "ready in reset", $itor(in_ready_o), 0.0);
    chk(out_valid_o == 1'b0, "R1", "valid in reset", $itor(out_valid_o), 0.0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready_o == 1'b0, "R1", "ready idle", $itor(in_ready_o), 0.0);
    chk(out_valid_o == 1'b0, "R1", "valid idle", $itor(out_valid_o), 0.0);

    run_batch('{0, 4289, -6434, 8000}, '{9949, 9949, 9949, 9949},
              '{0, 0, 0, 0}, '{0, 0, 0, 0}, 1'b1, 1'b1, "R5");
    run_batch('{12868, -12868, 1, -1}, '{9949, 9949, 9949, 9949},
              '{0, 0, 0, 0}, '{0, 0, 0, 0}, 1'b1, 1'b1, "R8");
    run_batch('{3000, -3000, 10000, -10000}, '{9949, 9949, 9949, 9949},
              '{0, 0, 0, 0}, '{2, 0, 3, 1}, 1'b1, 1'b1, "R3");
    run_batch('{2000, -7000, 12000, 0}, '{5000, -4000, 3000, 6000},
              '{3000, 2000, -5000, 6000}, '{0, 1, 0, 0}, 1'b1, 1'b1, "R6");

    // R7: abandon a batch part-way, then run a fresh one
    run_batch('{1000, 2000, 3000, 4000}, '{9949, 9949, 9949, 9949},
              '{0, 0, 0, 0}, '{0, 0, 0, 0}, 1'b0, 1'b0, "R7");
    repeat (5) @(posedge clk);
    run_batch('{-5000, 6000, -11000, 500}, '{9949, 9949, 9949, 9949},
              '{0, 0, 0, 0}, '{0, 0, 0, 0}, 1'b1, 1'b1, "R7");

    repeat (4) @(negedge clk);
    chk(q_c.size() == 0, "R5", "results missing", $itor(q_c.size()), 0.0);
    chk(!overlap_seen, "R9", "ready and valid together", $itor(overlap_seen), 0.0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule